// File: doc/BRIEF.md
# Dual-Lane Packed Multiply-Accumulate Unit

This unit is a single-issue arithmetic stage. It views every 64-bit operand as two independent 32-bit unsigned word lanes. One common operation runs on both lanes at once. A 64-bit accumulator, split into the same two lanes, is kept inside the unit.

An operation is offered with a 2-bit code and two 64-bit sources, A and B. The code selects one of four operations:

- Load the accumulator.
- Multiply each lane and add the product into the accumulator.
- Multiply each lane without touching the accumulator.
- A reserved code.

The 64-bit result is registered and appears one clock after the operation is accepted. The accumulator changes on that same edge, so a stream of accumulate operations can issue every cycle without stalls. For convenience, the upper and lower 32-bit halves of the result are also driven on their own outputs.

Top module: `simd_mac_unit`

## Requirements
- R1: While `rst_n` is low at a rising edge, the accumulator and `out_rd` clear to zero, and `out_valid` and `in_ready` are low. From the first edge with `rst_n` high onward, `in_ready` is high.
- R2: An operation is accepted at an edge where `in_valid` and `in_ready` are both high. At the following sample point, `out_valid` is high exactly when an operation was accepted at that edge.
- R3: Code 0 (load) copies `in_ra` into the accumulator and drives `in_ra` onto `out_rd`.
- R4: Code 1 (accumulate) works on each lane separately, where lane 0 is bits [31:0] and lane 1 is bits [63:32]. In each lane, the low 32 bits of the unsigned product of A and B are added to that lane's accumulator word modulo 2^32. The sum is written to both `out_rd` and the accumulator.
- R5: A carry or overflow in lane 0 never changes lane 1, and an overflow in lane 1 is dropped.
- R6: Code 2 (multiply) drives the per-lane low 32-bit products onto `out_rd` and leaves the accumulator unchanged.
- R7: Accumulate operations on consecutive cycles each use the accumulator value written by the operation just before, with no stall.
- R8: Code 3 (reserved) is accepted, drives zero onto `out_rd`, and leaves the accumulator unchanged.
- R9: `out_hi` always equals `out_rd[63:32]` and `out_lo` always equals `out_rd[31:0]`.
- R10: `out_rd` keeps its value across any cycle in which no operation is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | An operation is offered |
| in_ready | output | 1 | The unit can take an operation |
| in_op | input | 2 | Operation code: 0 load, 1 accumulate, 2 multiply, 3 reserved |
| in_ra | input | 64 | Source A, two 32-bit lanes |
| in_rb | input | 64 | Source B, two 32-bit lanes |
| out_valid | output | 1 | `out_rd` holds the result of the operation accepted at the last edge |
| out_rd | output | 64 | Registered result |
| out_hi | output | 32 | Upper half of `out_rd` |
| out_lo | output | 32 | Lower half of `out_rd` |

## Verification
The accumulator is internal, so it is observed by an accumulate with B equal to zero: that operation returns the accumulator unchanged on `out_rd`.

The assertions rely on three assumptions about the inputs:
- `in_op`, `in_ra` and `in_rb` are settled whenever `in_valid` is high.
- The caller treats any offered operation as consumed once `in_ready` is high.
- Nothing is offered while reset is active, or an offer made during reset is simply dropped.

The stimulus drives every input half a cycle away from the sampling edge. It presents only defined values and inserts idle cycles among the operations, so that both the hold behaviour and back-to-back accumulates are exercised.

// File: rtl/simd_mac_pkg.sv
// Package: shared operation encoding for the packed multiply-accumulate unit.
// Assumes a 2-bit operation field; all four codes are defined.
package simd_mac_pkg;
    localparam int OP_W = 2;

    typedef enum logic [OP_W-1:0] {
        OP_LOAD = 2'd0,
        OP_MACC = 2'd1,
        OP_MULT = 2'd2,
        OP_RSVD = 2'd3
    } mac_op_e;
endpackage

// File: rtl/smac_lane.sv
// Module: one word lane of the packed arithmetic. Produces the low word of the
// unsigned product of its two operands and that product added, modulo 2^W,
// to the lane's accumulator word. Purely combinational; assumes the caller
// selects which result is used.
module smac_lane #(
    parameter int LANE_W = 32
) (
    input  logic [LANE_W-1:0] op_a,
    input  logic [LANE_W-1:0] op_b,
    input  logic [LANE_W-1:0] acc_word,
    output logic [LANE_W-1:0] prod_lo,
    output logic [LANE_W-1:0] acc_sum
);
    localparam int PROD_W = 2 * LANE_W;

    logic [PROD_W-1:0] full_prod;

    // Full-width product, truncated to the low word.
    always_comb begin
        full_prod = PROD_W'(op_a) * PROD_W'(op_b);
        prod_lo   = full_prod[LANE_W-1:0];
    end

    // Modulo add: any carry out of the lane is dropped here.
    always_comb begin
        acc_sum = prod_lo + acc_word;
    end
endmodule

// File: rtl/smac_accum.sv
// Module: packed accumulator register. Clears under synchronous active-low
// reset and loads wr_data when wr_en is high. Assumes wr_en is only raised
// for accepted operations that are allowed to change the accumulator.
module smac_accum #(
    parameter int DATA_W = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] acc_q
);
    // Accumulator state update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q <= '0;
        end else if (wr_en) begin
            acc_q <= wr_data;
        end
    end

    AST_ACC_HOLD_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && !$past(wr_en) |-> acc_q == $past(acc_q)); // R6
endmodule

// File: rtl/simd_mac_unit.sv
// Module: top of the dual-lane packed multiply-accumulate unit.
// Accepts one operation per cycle when in_valid and in_ready are high.
// The result is registered one cycle later, and the accumulator updates on
// the same edge. Assumes inputs are stable around the sampling edge;
// out_valid is not back-pressured.
module simd_mac_unit
    import simd_mac_pkg::*;
#(
    parameter int LANE_W = 32,
    parameter int LANES  = 2
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     in_valid,
    output logic                     in_ready,
    input  logic [OP_W-1:0]          in_op,
    input  logic [LANES*LANE_W-1:0]  in_ra,
    input  logic [LANES*LANE_W-1:0]  in_rb,
    output logic                     out_valid,
    output logic [LANES*LANE_W-1:0]  out_rd,
    output logic [LANES*LANE_W/2-1:0] out_hi,
    output logic [LANES*LANE_W/2-1:0] out_lo
);
    localparam int DATA_W = LANES * LANE_W;
    localparam int HALF_W = DATA_W / 2;

    mac_op_e           op;
    logic              accepted;
    logic [DATA_W-1:0] acc_q;
    logic [DATA_W-1:0] prod_vec;
    logic [DATA_W-1:0] sum_vec;
    logic [DATA_W-1:0] rd_next;
    logic              acc_we;
    logic [DATA_W-1:0] acc_next;

    // Decode the operation code and the handshake.
    always_comb begin
        op       = mac_op_e'(in_op);
        accepted = in_valid && in_ready;
    end

    // One arithmetic lane per word element; carries stay inside each lane.
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        smac_lane #(.LANE_W(LANE_W)) u_lane (
            .op_a     (in_ra[g*LANE_W +: LANE_W]),
            .op_b     (in_rb[g*LANE_W +: LANE_W]),
            .acc_word (acc_q[g*LANE_W +: LANE_W]),
            .prod_lo  (prod_vec[g*LANE_W +: LANE_W]),
            .acc_sum  (sum_vec[g*LANE_W +: LANE_W])
        );
    end

    // Select the result and the accumulator write for the current operation.
    always_comb begin
        rd_next  = '0;
        acc_we   = 1'b0;
        acc_next = sum_vec;
        unique case (op)
            OP_LOAD: begin
                rd_next  = in_ra;
                acc_next = in_ra;
                acc_we   = accepted;
            end
            OP_MACC: begin
                rd_next  = sum_vec;
                acc_next = sum_vec;
                acc_we   = accepted;
            end
            OP_MULT: rd_next = prod_vec;
            OP_RSVD: rd_next = '0;
            default: rd_next = '0;
        endcase
    end

    smac_accum #(.DATA_W(DATA_W)) u_accum (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (acc_we),
        .wr_data (acc_next),
        .acc_q   (acc_q)
    );

    // Ready comes up one edge after reset is released.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            in_ready <= 1'b0;
        end else begin
            in_ready <= 1'b1;
        end
    end

    // Result register and valid flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_rd    <= '0;
        end else begin
            out_valid <= accepted;
            if (accepted) begin
                out_rd <= rd_next;
            end
        end
    end

    // Half-word views of the result.
    always_comb begin
        out_hi = out_rd[DATA_W-1:HALF_W];
        out_lo = out_rd[HALF_W-1:0];
    end

    AST_VALID_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> out_valid == $past(in_valid && in_ready)); // R2
    AST_LOAD_ECHO: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && $past(in_valid && in_ready && in_op == OP_LOAD)
        |-> out_rd == $past(in_ra) && acc_q == $past(in_ra)); // R3
    AST_MACC_RD_MATCHES_ACC: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && $past(in_valid && in_ready && in_op == OP_MACC)
        |-> out_rd == acc_q); // R4
    AST_MULT_KEEPS_ACC: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && $past(in_valid && in_ready && (in_op == OP_MULT || in_op == OP_RSVD))
        |-> $stable(acc_q)); // R6
    AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && $past(in_valid && in_ready && in_op == OP_RSVD)
        |-> out_rd == '0); // R8
    AST_RD_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && !$past(in_valid && in_ready) |-> $stable(out_rd)); // R10
endmodule

// File: tb/simd_mac_unit_tb_top.sv
// Bench: behavioural reference model compared against the outputs every cycle.
module simd_mac_unit_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [1:0]  in_op = 2'd0;
    logic [63:0] in_ra = '0;
    logic [63:0] in_rb = '0;
    logic        out_valid;
    logic [63:0] out_rd;
    logic [31:0] out_hi;
    logic [31:0] out_lo;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    // Reference state.
    logic [63:0] m_acc = '0;
    logic [63:0] m_rd = '0;
    logic        m_valid = 1'b0;

    always #5 clk = ~clk;

    simd_mac_unit dut_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_op(in_op), .in_ra(in_ra), .in_rb(in_rb), .out_valid(out_valid),
        .out_rd(out_rd), .out_hi(out_hi), .out_lo(out_lo)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] lane_of(input logic [63:0] v, input int l);
        return v[l*32 +: 32];
    endfunction

    function automatic logic [31:0] low_prod(input logic [31:0] a, input logic [31:0] b);
        longint unsigned p;
        p = longint'(a) * longint'(b);
        return p[31:0];
    endfunction

    // Drive one cycle, update the model, compare at the next falling edge.
    task automatic step(input string tag, input bit v, input logic [1:0] op,
                        input logic [63:0] a, input logic [63:0] b);
        logic [63:0] nrd;
        in_valid = v; in_op = op; in_ra = a; in_rb = b;
        if (v) begin
            nrd = '0;
            for (int l = 0; l < 2; l++) begin
                case (op)
                    2'd0: nrd[l*32 +: 32] = lane_of(a, l);
                    2'd1: nrd[l*32 +: 32] = low_prod(lane_of(a, l), lane_of(b, l)) + lane_of(m_acc, l);
                    2'd2: nrd[l*32 +: 32] = low_prod(lane_of(a, l), lane_of(b, l));
                    default: nrd[l*32 +: 32] = 32'd0;
                endcase
            end
            if (op == 2'd0 || op == 2'd1) m_acc = nrd;
            m_rd = nrd;
        end
        m_valid = v;
        @(negedge clk);
        chk({tag, " R2 valid"}, 64'(out_valid), 64'(m_valid));
        chk({tag, " rd"}, out_rd, m_rd);
        chk({tag, " R9 hi"}, 64'(out_hi), 64'(out_rd[63:32]));
        chk({tag, " R9 lo"}, 64'(out_lo), 64'(out_rd[31:0]));
        chk({tag, " R1 ready"}, 64'(in_ready), 64'd1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 reset valid", 64'(out_valid), 64'd0);
        chk("R1 reset ready", 64'(in_ready), 64'd0);
        chk("R1 reset rd", out_rd, 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 ready after reset", 64'(in_ready), 64'd1);
        step("R1 acc zero", 1, 2'd1, 64'd0, 64'd0);
        step("R3 load", 1, 2'd0, 64'h0000_0005_0000_0007, 64'hDEAD_BEEF_0000_0000);
        step("R4 macc", 1, 2'd1, 64'h0000_0003_0000_0004, 64'h0000_000A_0000_0014);
        step("R7 b2b 1", 1, 2'd1, 64'h0000_0002_0000_0002, 64'h0000_0002_0000_0003);
        step("R7 b2b 2", 1, 2'd1, 64'h0000_0001_0000_0001, 64'h0000_0001_0000_0001);
        step("R10 idle", 0, 2'd1, 64'h1234_5678_9ABC_DEF0, 64'h1);
        step("R10 idle2", 0, 2'd0, 64'hFFFF, 64'h0);
        step("R5 load", 1, 2'd0, 64'hFFFF_FFFF_FFFF_FFFF, 64'd0);
        step("R5 carry", 1, 2'd1, 64'h0000_0001_0000_0001, 64'h0000_0001_0000_0001);
        chk("R5 lanes wrap", out_rd, 64'd0);
        step("R4 bigprod", 1, 2'd1, 64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_0000_0002);
        chk("R4 bigprod val", out_rd, 64'h0000_0001_FFFF_FFFE);
        step("R6 mult", 1, 2'd2, 64'h0001_0000_8000_0000, 64'h0001_0000_0000_0003);
        chk("R6 mult val", out_rd, 64'h0000_0000_8000_0000);
        step("R6 acc kept", 1, 2'd1, 64'd0, 64'd0);
        step("R8 rsvd", 1, 2'd3, 64'hAAAA_AAAA_AAAA_AAAA, 64'h5555);
        step("R8 acc kept", 1, 2'd1, 64'd0, 64'd0);
        for (int i = 0; i < 300; i++) begin
            step("mix", ($urandom % 4) != 0, 2'($urandom),
                 {$urandom, $urandom}, {$urandom, $urandom});
        end
        step("R7 final read", 1, 2'd1, 64'd0, 64'd0);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog R2 actual=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule